// File: doc/BRIEF.md
# Downlink Channel Frame Timing Generator

This block derives the start strobes of several downlink physical channels from one chip-rate reference counter. A chip-rate enable advances the counter. It runs through a 38400-chip frame made of fifteen 2560-chip slots and keeps a 12-bit frame number. Every channel strobe is placed relative to the reference frame boundary. That boundary is shared by the synchronisation, pilot and primary common control channels.

The secondary common control channel and each dedicated channel start at their own programmed distance from the reference boundary, in steps of 256 chips. The paging indicator channel runs in one of two modes. In one it leads the secondary common control channel frame by 7680 chips. In the other it is aligned to the shared control channel frame. Acquisition indicator access slots last two slots, so they span pairs of frames. Shared control subframes last three slots each.

A synchronous load puts the counter and the frame number at any point, for example after cell search has fixed the timing. Offset settings and the paging mode are taken up only at a reference frame boundary, so a frame never holds a partial mix of old and new settings.

Top module: `dl_frame_timer`

## Requirements
- R1: After reset, every strobe output is low and `chip_phase`, `frame_num` and `as_idx` read 0. The active offsets are 0 and the paging mode is 7680-chip lead.
- R2: `chip_phase` advances by one on each clock with `chip_en` high and `load` low, and wraps from 38399 to 0. It holds when `chip_en` is low. `frame_start` is high for one cycle, the cycle in which `chip_phase` first reads 0 after a wrap.
- R3: `frame_num` increments together with `frame_start` and wraps from 4095 to 0. With `load` high, `chip_phase` takes `load_chip` (clamped to 38399) and `frame_num` takes `load_fn` on the next edge. The load has priority over `chip_en` and raises no strobe.
- R4: `slot_start` pulses whenever the advanced `chip_phase` is a multiple of 2560. `sub_start` pulses whenever it is a multiple of 7680.
- R5: `as_start` pulses at chip multiples of 5120 in even-numbered frames and at 2560 plus multiples of 5120 in odd-numbered frames. `as_idx` gives the current access slot index, 0 to 14, counted from chip 0 of an even frame.
- R6: `sc_start` pulses when the advanced `chip_phase` equals (`sc_ofs` mod 150) × 256.
- R7: Bit i of `dch_start` pulses when the advanced `chip_phase` equals (field i of `dch_ofs` mod 150) × 256. Field i sits at bits [8i+7:8i].
- R8: With `pich_on_hs` = 0, `pich_start` pulses 7680 chips before the secondary common control channel position, taken modulo 38400. With `pich_on_hs` = 1, it pulses together with `frame_start`.
- R9: `sc_ofs`, `dch_ofs` and `pich_on_hs` are sampled only on the edge that raises `frame_start`, and they already govern that chip-0 strobe. Changes made at other times, and loads, leave the active settings alone.
- R10: Each strobe lasts one cycle. Over a full frame of advances there are exactly 1 `frame_start`, 15 `slot_start`, 5 `sub_start`, 1 `sc_start`, 1 `pich_start` and 1 pulse on each `dch_start` bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chip_en | input | 1 | Advance by one chip |
| load | input | 1 | Load counter phase and frame number |
| load_fn | input | 12 | Frame number to load |
| load_chip | input | 16 | Chip phase to load |
| sc_ofs | input | 8 | Secondary common control offset, 256-chip units |
| dch_ofs | input | 16 | Dedicated channel offsets, 8 bits per channel |
| pich_on_hs | input | 1 | 1: paging aligned to shared control; 0: 7680-chip lead |
| chip_phase | output | 16 | Current chip within the frame |
| frame_num | output | 12 | Current frame number |
| as_idx | output | 4 | Current access slot index |
| frame_start | output | 1 | Reference frame strobe |
| slot_start | output | 1 | Slot strobe |
| sub_start | output | 1 | Shared control subframe strobe |
| as_start | output | 1 | Access slot strobe |
| sc_start | output | 1 | Secondary common control frame strobe |
| dch_start | output | 2 | Dedicated channel frame strobes |
| pich_start | output | 1 | Paging indicator frame strobe |

## Verification
The hardest case to reach is the moment new offsets take over. It only happens on the one edge that wraps the frame, and the strobes compared on that edge must already use the new values. The stimulus changes `sc_ofs` in mid-frame and then loads a phase at that channel's old position, which shows the old setting still in force. It then loads phase 38399 and advances once, so the wrap, the chip-0 strobe under the new zero offset and the relocated paging lead can all be checked within a few cycles. The same load-then-advance method puts each far boundary, such as odd-frame access slots and the frame-number rollover at 4095, within one cycle of the stimulus. One full frame of advances then counts every strobe.

// File: rtl/dl_frame_timer.sv
module dl_frame_timer #(
  parameter int FRAME_CHIPS = 38400,
  parameter int SLOT_CHIPS  = 2560,
  parameter int OFS_UNIT    = 256,
  parameter int PICH_LEAD   = 7680,
  parameter int SUB_SLOTS   = 3,
  parameter int FN_W        = 12,
  parameter int OFS_W       = 8,
  parameter int NUM_DCH     = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     chip_en,
  input  logic                     load,
  input  logic [FN_W-1:0]          load_fn,
  input  logic [15:0]              load_chip,
  input  logic [OFS_W-1:0]         sc_ofs,
  input  logic [NUM_DCH*OFS_W-1:0] dch_ofs,
  input  logic                     pich_on_hs,
  output logic [15:0]              chip_phase,
  output logic [FN_W-1:0]          frame_num,
  output logic [3:0]               as_idx,
  output logic                     frame_start,
  output logic                     slot_start,
  output logic                     sub_start,
  output logic                     as_start,
  output logic                     sc_start,
  output logic [NUM_DCH-1:0]       dch_start,
  output logic                     pich_start
);
  localparam int CNT_W      = 16;
  localparam int SLOTS      = FRAME_CHIPS / SLOT_CHIPS;
  localparam int SLOT_W     = $clog2(SLOTS);
  localparam int PH_W       = $clog2(SLOT_CHIPS);
  localparam int OFS_STEPS  = FRAME_CHIPS / OFS_UNIT;
  localparam int LEAD_STEPS = PICH_LEAD / OFS_UNIT;
  localparam logic [CNT_W-1:0] LAST_CHIP = CNT_W'(FRAME_CHIPS - 1);

  function automatic logic [OFS_W-1:0] reduce(input logic [OFS_W-1:0] v);
    return OFS_W'(32'(v) % OFS_STEPS);
  endfunction

  function automatic logic [CNT_W-1:0] to_chip(input logic [OFS_W-1:0] s);
    return CNT_W'(32'(s) * OFS_UNIT);
  endfunction

  logic [CNT_W-1:0]  cnt;
  logic [PH_W-1:0]   ph;
  logic [SLOT_W-1:0] slot;
  logic [FN_W-1:0]   fn;
  logic [OFS_W-1:0]  sc_act;
  logic [OFS_W-1:0]  dch_act [NUM_DCH];
  logic              hs_act;

  wire adv      = chip_en && !load;
  wire wrap     = cnt == LAST_CHIP;
  wire ph_last  = ph == PH_W'(SLOT_CHIPS - 1);
  wire slot_last = slot == SLOT_W'(SLOTS - 1);

  wire [CNT_W-1:0]  nxt_cnt  = wrap ? '0 : cnt + 1'b1;
  wire [PH_W-1:0]   nxt_ph   = ph_last ? '0 : ph + 1'b1;
  wire [SLOT_W-1:0] nxt_slot = ph_last ? (slot_last ? '0 : slot + 1'b1) : slot;
  wire [FN_W-1:0]   nxt_fn   = fn + FN_W'(wrap);

  wire [OFS_W-1:0] sc_sel = wrap ? reduce(sc_ofs) : sc_act;
  wire             hs_sel = wrap ? pich_on_hs : hs_act;
  wire [OFS_W-1:0] pich_steps = (32'(sc_sel) >= LEAD_STEPS)
                                ? OFS_W'(32'(sc_sel) - LEAD_STEPS)
                                : OFS_W'(32'(sc_sel) + OFS_STEPS - LEAD_STEPS);
  wire [CNT_W-1:0] pich_pos = hs_sel ? '0 : to_chip(pich_steps);

  logic [OFS_W-1:0] dch_sel [NUM_DCH];
  always_comb
    for (int i = 0; i < NUM_DCH; i++)
      dch_sel[i] = wrap ? reduce(dch_ofs[i*OFS_W +: OFS_W]) : dch_act[i];

  wire [CNT_W-1:0] ld_chip = (load_chip > LAST_CHIP) ? LAST_CHIP : load_chip;
  logic [SLOT_W-1:0] ld_slot;
  logic [CNT_W-1:0]  ld_base;
  always_comb begin
    ld_slot = '0;
    ld_base = '0;
    for (int i = 1; i < SLOTS; i++)
      if (ld_chip >= CNT_W'(i * SLOT_CHIPS)) begin
        ld_slot = SLOT_W'(i);
        ld_base = CNT_W'(i * SLOT_CHIPS);
      end
  end

  wire slot_hit = adv && (nxt_ph == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      ph <= '0;
      slot <= '0;
      fn <= '0;
      sc_act <= '0;
      hs_act <= 1'b0;
      for (int i = 0; i < NUM_DCH; i++) dch_act[i] <= '0;
    end else if (load) begin
      cnt <= ld_chip;
      ph <= PH_W'(ld_chip - ld_base);
      slot <= ld_slot;
      fn <= load_fn;
    end else if (chip_en) begin
      cnt <= nxt_cnt;
      ph <= nxt_ph;
      slot <= nxt_slot;
      fn <= nxt_fn;
      if (wrap) begin
        sc_act <= sc_sel;
        hs_act <= hs_sel;
        for (int i = 0; i < NUM_DCH; i++) dch_act[i] <= dch_sel[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_start <= 1'b0;
      slot_start <= 1'b0;
      sub_start <= 1'b0;
      as_start <= 1'b0;
      sc_start <= 1'b0;
      pich_start <= 1'b0;
      dch_start <= '0;
    end else begin
      frame_start <= adv && wrap;
      slot_start <= slot_hit;
      sub_start <= slot_hit && ((32'(nxt_slot) % SUB_SLOTS) == 0);
      as_start <= slot_hit && (nxt_slot[0] == nxt_fn[0]);
      sc_start <= adv && (nxt_cnt == to_chip(sc_sel));
      pich_start <= adv && (nxt_cnt == pich_pos);
      for (int i = 0; i < NUM_DCH; i++)
        dch_start[i] <= adv && (nxt_cnt == to_chip(dch_sel[i]));
    end
  end

  assign chip_phase = cnt;
  assign frame_num = fn;
  assign as_idx = 4'((32'(slot) + (fn[0] ? SLOTS : 0)) >> 1);
endmodule

// File: rtl/dl_frame_timer_chk.sv
module dl_frame_timer_chk #(
  parameter int SLOT_CHIPS = 2560,
  parameter int FN_W       = 12
) (
  input logic            clk,
  input logic            rst_n,
  input logic            chip_en,
  input logic            load,
  input logic [15:0]     chip_phase,
  input logic [FN_W-1:0] frame_num,
  input logic            frame_start,
  input logic            slot_start,
  input logic            sub_start,
  input logic            as_start,
  input logic            sc_start
);
  // R2
  frame_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> chip_phase == 16'd0);

  // R2
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!chip_en && !load) |=> $stable(chip_phase));

  // R3
  fn_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> frame_num == $past(frame_num) + 1'b1);

  // R4
  slot_grid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slot_start |-> (32'(chip_phase) % SLOT_CHIPS) == 0);

  // R4
  sub_on_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sub_start |-> slot_start);

  // R5
  as_on_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    as_start |-> slot_start);

  // R10
  frame_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> !frame_start);

  // R10
  sc_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sc_start |=> !sc_start);
endmodule

bind dl_frame_timer dl_frame_timer_chk #(.SLOT_CHIPS(SLOT_CHIPS), .FN_W(FN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .chip_en(chip_en), .load(load),
  .chip_phase(chip_phase), .frame_num(frame_num), .frame_start(frame_start),
  .slot_start(slot_start), .sub_start(sub_start), .as_start(as_start),
  .sc_start(sc_start)
);

// File: tb/dl_frame_timer_bench.sv
module dl_frame_timer_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic chip_en = 1'b0, load = 1'b0, pich_on_hs = 1'b0;
  logic [11:0] load_fn = '0;
  logic [15:0] load_chip = '0;
  logic [7:0]  sc_ofs = '0;
  logic [15:0] dch_ofs = '0;
  logic [15:0] chip_phase;
  logic [11:0] frame_num;
  logic [3:0]  as_idx;
  logic frame_start, slot_start, sub_start, as_start, sc_start, pich_start;
  logic [1:0] dch_start;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  dl_frame_timer u_dl_frame_timer (
    .clk(clk), .rst_n(rst_n), .chip_en(chip_en), .load(load),
    .load_fn(load_fn), .load_chip(load_chip), .sc_ofs(sc_ofs),
    .dch_ofs(dch_ofs), .pich_on_hs(pich_on_hs), .chip_phase(chip_phase),
    .frame_num(frame_num), .as_idx(as_idx), .frame_start(frame_start),
    .slot_start(slot_start), .sub_start(sub_start), .as_start(as_start),
    .sc_start(sc_start), .dch_start(dch_start), .pich_start(pich_start)
  );

  wire [7:0] mask = {frame_start, slot_start, sub_start, as_start,
                     sc_start, pich_start, dch_start};

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  task automatic do_load(input logic [15:0] c, input logic [11:0] f);
    @(negedge clk);
    load = 1'b1; load_chip = c; load_fn = f;
    @(posedge clk); #1;
    @(negedge clk);
    load = 1'b0;
  endtask

  task automatic step;
    @(negedge clk);
    chip_en = 1'b1;
    @(posedge clk); #1;
    @(negedge clk);
    chip_en = 1'b0;
  endtask

  // {chip before advance, frame number, strobe mask, as_idx, frame number after}
  // mask: frame, slot, sub, as, sc, pich, dch1, dch0
  localparam logic [51:0] VEC [13] = '{
    {16'd38399, 12'd4,    8'hE0, 4'd7,  12'd5},
    {16'd38399, 12'd5,    8'hF0, 4'd0,  12'd6},
    {16'd2559,  12'd6,    8'h40, 4'd0,  12'd6},
    {16'd2559,  12'd7,    8'h50, 4'd8,  12'd7},
    {16'd5119,  12'd7,    8'h42, 4'd8,  12'd7},
    {16'd5119,  12'd6,    8'h52, 4'd1,  12'd6},
    {16'd7679,  12'd6,    8'h60, 4'd1,  12'd6},
    {16'd8959,  12'd6,    8'h08, 4'd1,  12'd6},
    {16'd1279,  12'd0,    8'h04, 4'd0,  12'd0},
    {16'd38143, 12'd9,    8'h01, 4'd14, 12'd9},
    {16'd35839, 12'd2,    8'h50, 4'd7,  12'd2},
    {16'd1000,  12'd3,    8'h00, 4'd7,  12'd3},
    {16'd38399, 12'd4095, 8'hF0, 4'd0,  12'd0}
  };

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog: actual 1 expected 0");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    check("R1 mask", int'(mask), 0);
    check("R1 chip_phase", int'(chip_phase), 0);
    check("R1 frame_num", int'(frame_num), 0);
    check("R1 as_idx", int'(as_idx), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R2 idle hold
    repeat (4) @(posedge clk);
    #1;
    check("R2 idle hold", int'(chip_phase), 0);

    sc_ofs = 8'd35;
    dch_ofs = {8'd170, 8'd149};
    do_load(16'd38399, 12'd0);
    check("R3 load no strobe", int'(mask), 0);
    check("R3 load phase", int'(chip_phase), 38399);
    step();
    check("R2 wrap frame_start", int'(frame_start), 1);

    for (int v = 0; v < 13; v++) begin
      logic [15:0] c;
      c = VEC[v][51:36];
      do_load(c, VEC[v][35:24]);
      @(negedge clk);
      chip_en = 1'b1;
      @(posedge clk); #1;
      // R4 R5 R6 R7 R8 strobes, R3 frame number
      check($sformatf("R4-R8 mask vec%0d", v), int'(mask), int'(VEC[v][23:16]));
      check($sformatf("R5 as_idx vec%0d", v), int'(as_idx), int'(VEC[v][15:12]));
      check($sformatf("R3 frame_num vec%0d", v), int'(frame_num), int'(VEC[v][11:0]));
      check($sformatf("R2 phase vec%0d", v), int'(chip_phase),
            (int'(c) == 38399) ? 0 : int'(c) + 1);
      @(negedge clk);
      chip_en = 1'b0;
      @(posedge clk); #1;
      check($sformatf("R10 single cycle vec%0d", v), int'(mask), 0);
    end

    // R9: mid-frame change has no effect yet
    sc_ofs = 8'd0;
    do_load(16'd8959, 12'd6);
    step();
    check("R9 old sc offset kept", int'(sc_start), 1);
    // R9: new offset applies at the chip-0 strobe
    do_load(16'd38399, 12'd6);
    step();
    check("R9 frame_start", int'(frame_start), 1);
    check("R9 sc at chip 0", int'(sc_start), 1);
    // R8: lead wraps into previous frame, (0+120)*256 = 30720
    do_load(16'd30719, 12'd7);
    step();
    check("R8 pich lead wrapped", int'(pich_start), 1);
    // R8: paired with shared control
    pich_on_hs = 1'b1;
    do_load(16'd30719, 12'd7);
    step();
    check("R9 pich mode not yet active", int'(pich_start), 1);
    do_load(16'd38399, 12'd7);
    step();
    check("R8 pich on frame start", int'(pich_start), 1);
    do_load(16'd30719, 12'd8);
    step();
    check("R8 pich lead gone", int'(pich_start), 0);

    // R10 full frame count from chip 0 of an even frame
    do_load(16'd0, 12'd6);
    begin
      int n_fr = 0, n_sl = 0, n_sub = 0, n_as = 0, n_sc = 0, n_pi = 0, n_d0 = 0, n_d1 = 0;
      @(negedge clk);
      chip_en = 1'b1;
      for (int k = 0; k < 38400; k++) begin
        @(posedge clk); #1;
        n_fr += int'(frame_start); n_sl += int'(slot_start);
        n_sub += int'(sub_start); n_as += int'(as_start);
        n_sc += int'(sc_start); n_pi += int'(pich_start);
        n_d0 += int'(dch_start[0]); n_d1 += int'(dch_start[1]);
      end
      @(negedge clk);
      chip_en = 1'b0;
      check("R10 frame count", n_fr, 1);
      check("R10 slot count", n_sl, 15);
      check("R10 sub count", n_sub, 5);
      check("R5 as count even frame", n_as, 7);
      check("R10 sc count", n_sc, 1);
      check("R10 pich count", n_pi, 1);
      check("R7 dch0 count", n_d0, 1);
      check("R7 dch1 count", n_d1, 1);
      check("R3 frame_num after frame", int'(frame_num), 7);
    end
    finish_run();
  end
endmodule